// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Edge Interrupts

This block is a 16-pin general-purpose I/O port with a simple register bus. Software sets each pin as an input or an output. It writes the values driven on the output pins and reads back the sampled input pins, filtered through a per-pin enable mask.

Every input pin goes through a two-flop synchronizer. After that, an edge detector compares the current sampled value with the value from the previous clock. Each pin has one polarity bit that chooses whether a rising or a falling edge is of interest. A chosen edge on an unmasked input pin sets a sticky status bit. A single interrupt line stays high while any status bit is set. Software clears status bits by writing ones to them.

Only 16-bit accesses to word-aligned, mapped offsets are accepted. Any other access is refused and reported on an error pulse that lasts one cycle.

Top module: `gpio16_port`

## Requirements
- R1: Register byte offsets are 0x00 input data, 0x04 output data, 0x08 direction, 0x0C edge select, 0x10 interrupt mask, 0x14 interrupt status and 0x18 pin enable. Read data and the error flag are registered and appear the cycle after the access. After reset, output, direction, edge select, mask and pin enable read 0xFFFF, status reads 0x0000 and irq is low.
- R2: A direction bit of 0 makes that pin an output, so pin_oe equals the inverted direction register. pin_out carries the output register on output pins and 0 on input pins.
- R3: Reading offset 0x00 returns the input pins, delayed by a two-flop synchronizer, ANDed with the pin-enable register.
- R4: An edge-select bit of 1 chooses a rising edge and a bit of 0 chooses a falling edge. The edge is judged between two consecutive synchronized samples. A chosen edge sets the status bit three clocks after the pin changes. An edge of the opposite polarity sets nothing.
- R5: An edge sets no status bit when the pin is an output (direction 0) or when its mask bit is 1.
- R6: Writing the status register clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R7: irq is high whenever any status bit is set. It goes low only in the cycle after the write that leaves all 16 status bits at zero.
- R8: When an edge event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R9: Writes to offset 0x00 change no register.
- R10: bus_width 2'b01 means a 16-bit access, and that is the only width accepted. Any other width changes no register, returns read data 0 and pulses bus_err for one cycle.
- R11: An access to an offset that is unmapped or not word-aligned returns read data 0 and pulses bus_err for one cycle. A mapped 16-bit access leaves bus_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_width | input | 2 | Access size code, 2'b01 means 16 bits |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for a refused access |
| pin_in | input | 16 | Asynchronous input pins |
| pin_out | output | 16 | Output pin values |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
Two things can hit the status register in the same cycle: a synchronized edge setting a bit, and a software write clearing that same bit. The bench provokes this by changing a pin on a falling clock edge. It then times a write of 1 to that status bit so the write is sampled on the third rising edge, which is the edge where the event lands. It judges the outcome by reading the status register back and checking that the bit is still set and that irq is still high. It also checks ordinary clearing and status sets in separate cycles, so that a design which only passes the collision case is exposed.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
    localparam int unsigned GPIO_W    = 16;
    localparam int unsigned BUS_AW    = 8;
    localparam int unsigned REG_COUNT = 7;
    localparam logic [1:0]  ACC_W16   = 2'b01;

    typedef enum logic [2:0] {
        RG_INPUT  = 3'd0,
        RG_OUTPUT = 3'd1,
        RG_DIR    = 3'd2,
        RG_EDGE   = 3'd3,
        RG_MASK   = 3'd4,
        RG_STATUS = 3'd5,
        RG_PINEN  = 3'd6
    } reg_idx_e;
endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio16_edge.sv
module gpio16_edge #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sample,
    input  logic [WIDTH-1:0] dir_in,
    input  logic [WIDTH-1:0] rise_sel,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] event_hit
);
    logic [WIDTH-1:0] prev_d, prev_q;
    logic [WIDTH-1:0] rise, fall;

    always_comb begin
        prev_d    = sample;
        rise      = sample & ~prev_q;
        fall      = ~sample & prev_q;
        event_hit = ((rise_sel & rise) | (~rise_sel & fall)) & dir_in & ~mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
    import gpio16_pkg::*;
#(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_width,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  sample,
    input  logic [WIDTH-1:0]  event_hit,
    output logic [WIDTH-1:0]  out_val,
    output logic [WIDTH-1:0]  dir_val,
    output logic [WIDTH-1:0]  rise_val,
    output logic [WIDTH-1:0]  mask_val,
    output logic [WIDTH-1:0]  rdata,
    output logic              err,
    output logic              irq
);
    localparam int unsigned IW = ADDR_W - 2;
    localparam logic [IW-1:0] NREG = IW'(REG_COUNT);

    typedef struct packed {
        logic [WIDTH-1:0] outv;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] rise;
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] sts;
        logic [WIDTH-1:0] pinen;
        logic [WIDTH-1:0] rdata;
        logic             err;
        logic             irq;
    } regs_t;

    regs_t            st_d, st_q;
    logic [IW-1:0]    word_idx;
    reg_idx_e         idx;
    logic             size_ok, hit, wr_sts;
    logic [WIDTH-1:0] clr;

    always_comb begin
        word_idx = bus_addr[ADDR_W-1:2];
        idx      = reg_idx_e'(word_idx[2:0]);
        size_ok  = (bus_width == ACC_W16);
        hit      = (bus_addr[1:0] == 2'b00) && (word_idx < NREG);
        wr_sts   = bus_en && bus_we && size_ok && hit && (idx == RG_STATUS);

        st_d     = st_q;
        st_d.err = 1'b0;
        clr      = '0;
        if (bus_en) begin
            if (!size_ok || !hit) begin
                st_d.err   = 1'b1;
                st_d.rdata = '0;
            end else if (bus_we) begin
                case (idx)
                    RG_OUTPUT: st_d.outv  = bus_wdata;
                    RG_DIR:    st_d.dir   = bus_wdata;
                    RG_EDGE:   st_d.rise  = bus_wdata;
                    RG_MASK:   st_d.mask  = bus_wdata;
                    RG_STATUS: clr        = bus_wdata;
                    RG_PINEN:  st_d.pinen = bus_wdata;
                    default:   ;
                endcase
            end else begin
                case (idx)
                    RG_INPUT:  st_d.rdata = sample & st_q.pinen;
                    RG_OUTPUT: st_d.rdata = st_q.outv;
                    RG_DIR:    st_d.rdata = st_q.dir;
                    RG_EDGE:   st_d.rdata = st_q.rise;
                    RG_MASK:   st_d.rdata = st_q.mask;
                    RG_STATUS: st_d.rdata = st_q.sts;
                    RG_PINEN:  st_d.rdata = st_q.pinen;
                    default:   st_d.rdata = '0;
                endcase
            end
        end
        // A new event is ORed in after the clear, so the set wins.
        st_d.sts = (st_q.sts & ~clr) | event_hit;
        st_d.irq = |st_d.sts;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.outv  <= '1;
            st_q.dir   <= '1;
            st_q.rise  <= '1;
            st_q.mask  <= '1;
            st_q.sts   <= '0;
            st_q.pinen <= '1;
            st_q.rdata <= '0;
            st_q.err   <= 1'b0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_val  = st_q.outv;
    assign dir_val  = st_q.dir;
    assign rise_val = st_q.rise;
    assign mask_val = st_q.mask;
    assign rdata    = st_q.rdata;
    assign err      = st_q.err;
    assign irq      = st_q.irq;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_hit) |=> ((st_q.sts & $past(event_hit)) == $past(event_hit)));

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && ((event_hit & bus_wdata) == '0)) |=> ((st_q.sts & $past(bus_wdata)) == '0));

    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !wr_sts) |=> st_q.irq);

    a_r7_irq_low_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.irq |-> (st_q.sts == '0));

    a_r10_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && (bus_width != ACC_W16)) |=> (st_q.err && (st_q.rdata == '0)));

    a_r11_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && size_ok && !hit) |=> (st_q.err && (st_q.rdata == '0)));
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
    import gpio16_pkg::*;
#(
    parameter int unsigned WIDTH       = GPIO_W,
    parameter int unsigned ADDR_W      = BUS_AW,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_width,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0] sample, event_hit, out_val, dir_val, rise_val, mask_val;

    gpio16_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_d (pin_in),
        .sync_q  (sample)
    );

    gpio16_edge #(.WIDTH(WIDTH)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .dir_in    (dir_val),
        .rise_sel  (rise_val),
        .mask      (mask_val),
        .event_hit (event_hit)
    );

    gpio16_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_width (bus_width),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sample    (sample),
        .event_hit (event_hit),
        .out_val   (out_val),
        .dir_val   (dir_val),
        .rise_val  (rise_val),
        .mask_val  (mask_val),
        .rdata     (bus_rdata),
        .err       (bus_err),
        .irq       (irq)
    );

    assign pin_oe  = ~dir_val;
    assign pin_out = out_val & ~dir_val;
endmodule

// File: tb/gpio16_port_tb.sv
module gpio16_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_IN = 8'h00, A_OUT = 8'h04, A_DIR = 8'h08, A_EDGE = 8'h0C,
                           A_MASK = 8'h10, A_STS = 8'h14, A_PEN = 8'h18;
    localparam logic [1:0] W16 = 2'b01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_width = W16;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic        bus_err, irq;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit          is_rd;
        logic [15:0] data;
        bit          err;
        string       tag;
    } item_t;
    item_t exp_q[$];
    logic  acc_q = 1'b0;

    gpio16_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_width(bus_width), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) acc_q <= bus_en;

    // Monitor: compares the registered response the cycle after each access.
    always @(negedge clk) begin
        if (acc_q) begin
            if (exp_q.size() == 0) begin
                chk("monitor_underflow", 16'h0001, 16'h0000);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk({it.tag, "_err"}, {15'd0, bus_err}, {15'd0, it.err});
                if (it.is_rd) chk(it.tag, bus_rdata, it.data);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_en = 1'b0;
            bus_we = 1'b0;
        end
    endtask

    task automatic access(input bit we, input logic [1:0] w, input logic [7:0] a,
                          input logic [15:0] d, input logic [15:0] exp, input bit exp_err,
                          input string tag);
        item_t it;
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_width = w; bus_addr = a; bus_wdata = d;
        it.is_rd = !we; it.data = exp; it.err = exp_err; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
        access(1'b1, W16, a, d, 16'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        access(1'b0, W16, a, 16'h0, exp, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset values
        chk("R1_irq_reset", {15'd0, irq}, 16'h0);
        chk("R2_oe_reset", pin_oe, 16'h0000);
        rd(A_OUT, 16'hFFFF, "R1_out_reset");
        rd(A_DIR, 16'hFFFF, "R1_dir_reset");
        rd(A_EDGE, 16'hFFFF, "R1_edge_reset");
        rd(A_MASK, 16'hFFFF, "R1_mask_reset");
        rd(A_STS, 16'h0000, "R1_sts_reset");
        rd(A_PEN, 16'hFFFF, "R1_pen_reset");
        rd(A_IN, 16'h0000, "R1_in_reset");
        // R2 output drive
        wr(A_DIR, 16'h00FF, "R2_wr_dir");
        wr(A_OUT, 16'hA5C3, "R2_wr_out");
        idle(1);
        chk("R2_oe", pin_oe, 16'hFF00);
        chk("R2_out", pin_out, 16'hA500);
        // R3 synchronized input with pin enable
        wr(A_DIR, 16'hFFFF, "R3_wr_dir");
        wr(A_PEN, 16'h0FF0, "R3_wr_pen");
        idle(1);
        pin_in = 16'h1234;
        idle(4);
        rd(A_IN, 16'h0230, "R3_in_read");
        idle(1);
        chk("R2_out_all_inputs", pin_out, 16'h0000);
        pin_in = 16'h0000;
        idle(4);
        rd(A_STS, 16'h0000, "R5_masked_no_status");
        // R4 polarity
        wr(A_EDGE, 16'h0001, "R4_wr_edge");
        wr(A_MASK, 16'hFFFC, "R4_wr_mask");
        idle(1);
        pin_in = 16'h0003;
        idle(4);
        rd(A_STS, 16'h0001, "R4_rise_sets_only_rise_pin");
        idle(1);
        chk("R7_irq_set", {15'd0, irq}, 16'h1);
        pin_in = 16'h0000;
        idle(4);
        rd(A_STS, 16'h0003, "R4_fall_sets_fall_pin");
        // R5 output pin and masked pin blocked
        wr(A_MASK, 16'hFFF8, "R5_wr_mask");
        wr(A_DIR, 16'hFFFB, "R5_wr_dir");
        wr(A_EDGE, 16'h000F, "R5_wr_edge");
        idle(1);
        pin_in = 16'h000C;
        idle(4);
        rd(A_STS, 16'h0003, "R5_output_and_masked_blocked");
        // R6 / R7 clearing
        wr(A_STS, 16'h0001, "R6_clear_bit0");
        idle(1);
        chk("R7_irq_stays", {15'd0, irq}, 16'h1);
        rd(A_STS, 16'h0002, "R6_bit1_left");
        wr(A_STS, 16'h0002, "R6_clear_bit1");
        idle(1);
        chk("R7_irq_low", {15'd0, irq}, 16'h0);
        rd(A_STS, 16'h0000, "R6_all_clear");
        // R8 set beats clear in the same cycle
        idle(1);
        pin_in = 16'h000D;
        idle(1);
        wr(A_STS, 16'h0001, "R8_clear_on_event");
        idle(1);
        chk("R8_irq_high", {15'd0, irq}, 16'h1);
        rd(A_STS, 16'h0001, "R8_set_wins");
        wr(A_STS, 16'hFFFF, "R8_cleanup");
        // R9 input register is read only
        wr(A_PEN, 16'hFFFF, "R9_wr_pen");
        wr(A_IN, 16'hFFFF, "R9_wr_input");
        rd(A_IN, 16'h000D, "R9_input_unchanged");
        rd(A_OUT, 16'hA5C3, "R9_out_unchanged");
        rd(A_PEN, 16'hFFFF, "R9_pen_unchanged");
        // R10 wrong widths
        access(1'b1, 2'b10, A_OUT, 16'h1111, 16'h0, 1'b1, "R10_wide_write");
        rd(A_OUT, 16'hA5C3, "R10_out_unchanged");
        access(1'b0, 2'b00, A_DIR, 16'h0, 16'h0000, 1'b1, "R10_byte_read");
        // R11 unmapped and misaligned
        access(1'b0, W16, 8'h1C, 16'h0, 16'h0000, 1'b1, "R11_unmapped_read");
        access(1'b0, W16, 8'h06, 16'h0, 16'h0000, 1'b1, "R11_misaligned_read");
        rd(A_DIR, 16'hFFFB, "R11_mapped_no_err");
        idle(3);
        chk("scoreboard_drained", 16'(exp_q.size()), 16'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule